// File: doc/BRIEF.md
# Cascadable Loadable Synchronous Counter

This block is a synchronous binary up-counter of parameterised width (four bits by default). Every change of state happens on the rising clock edge. An active-low clear forces the count to zero. An active-low load copies a parallel data word into the count. Counting happens only when two enables are both high: a parallel enable and a trickle enable. The fixed priority is clear first, then load, then count. If none of these applies, the count holds.

A carry output goes high when the count is all ones and the trickle enable is high. The parallel enable plays no part in it. The carry is combinational, so it is valid in the same cycle. To build a wider counter, drive the next stage's trickle enable from this carry, and share the clock, clear, load and parallel enable across all stages. No glue logic is needed.

Top module: `cascade_counter`

## Requirements
- R1: While clear_n is 0 at a rising edge, the count becomes 0 after that edge, whatever load_n, data_in and the enables are.
- R2: While clear_n is 1 and load_n is 0 at a rising edge, the count takes data_in after that edge, whatever the two enables are.
- R3: While clear_n and load_n are both 1 and en_par and en_trk are both 1, the count increases by one at each rising edge.
- R4: While clear_n and load_n are both 1 and at least one of en_par or en_trk is 0, the count does not change.
- R5: When the count is all ones (15 at width 4) and a count step happens, the next value is 0.
- R6: carry_out is 1 exactly when en_trk is 1 and the count is all ones. It follows en_trk within the same cycle and does not depend on en_par.
- R7: Two stages, with the first stage's carry_out driving the second stage's en_trk and all other controls shared, behave as one counter of twice the width. This includes loading, clearing and wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| data_in | input | W | Value captured on load |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates carry_out |
| count | output | W | Current count |
| carry_out | output | 1 | All-ones count while en_trk is high |

## Verification
Clear, load and count can all be requested on the same edge. The bench drives random mixes in which clear_n, load_n and both enables are low or high together, including a load in the middle of a run of counting and a clear arriving together with a load. A reference model of the combined 8-bit value applies the clear > load > count order, and the bench compares the count after each edge with the model. The carry is also requested in the same cycle as a count step that crosses from the low stage into the high stage. The bench checks it combinationally before each edge, with en_par low and with en_par high.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_STEP  = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    typedef struct packed {
        logic clear_n;
        logic load_n;
        logic en_par;
        logic en_trk;
    } cnt_ctrl_t;

    function automatic cnt_op_e pick_op(input cnt_ctrl_t c);
        if (!c.clear_n)                 return OP_CLEAR;
        else if (!c.load_n)             return OP_LOAD;
        else if (c.en_par && c.en_trk)  return OP_STEP;
        else                            return OP_HOLD;
    endfunction

endpackage

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
    import cascade_counter_pkg::*;
(
    input  cnt_ctrl_t ctrl,
    output cnt_op_e   op
);
    always_comb op = pick_op(ctrl);
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state
    import cascade_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  cnt_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_STEP:  nxt = cur + ONE;
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         en_trk,
    output logic         carry
);
    logic [W:0] chain;

    assign chain[0] = en_trk;
    for (genvar i = 0; i < W; i++) begin : g_and
        assign chain[i+1] = chain[i] & cur[i];
    end
    assign carry = chain[W];
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic [W-1:0] data_in,
    input  logic         en_par,
    input  logic         en_trk,
    output logic [W-1:0] count,
    output logic         carry_out
);
    cnt_ctrl_t    ctrl;
    cnt_op_e      op;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    assign ctrl = '{clear_n: clear_n, load_n: load_n, en_par: en_par, en_trk: en_trk};

    cnt_op_decode u_decode (
        .ctrl (ctrl),
        .op   (op)
    );

    cnt_next_state #(.W(W)) u_next (
        .op  (op),
        .cur (cnt_q),
        .din (data_in),
        .nxt (cnt_d)
    );

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    cnt_carry #(.W(W)) u_carry (
        .cur    (cnt_q),
        .en_trk (en_trk),
        .carry  (carry_out)
    );

    assign count = cnt_q;
endmodule

// File: rtl/cascade_counter_chk.sv
module cascade_counter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clear_n,
    input logic         load_n,
    input logic [W-1:0] data_in,
    input logic         en_par,
    input logic         en_trk,
    input logic [W-1:0] count,
    input logic         carry_out
);
    // The count is undefined until the first clear, so checking starts after it.
    logic armed = 1'b0;
    always_ff @(posedge clk) if (!clear_n) armed <= 1'b1;

    a_r1_clear_zero: assert property (@(posedge clk) disable iff (!armed)
        !clear_n |=> count == '0);

    a_r2_load_capture: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && !load_n) |=> count == $past(data_in));

    a_r3_step: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && en_par && en_trk) |=> count == W'($past(count) + W'(1)));

    a_r4_hold: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && !(en_par && en_trk)) |=> $stable(count));

    a_r5_wrap: assert property (@(posedge clk) disable iff (!armed)
        (clear_n && load_n && en_par && en_trk && (&count)) |=> count == '0);

    a_r6_carry_needs_trk: assert property (@(posedge clk) disable iff (!armed)
        carry_out |-> (en_trk && (&count)));

    a_r6_carry_when_full: assert property (@(posedge clk) disable iff (!armed)
        (en_trk && (&count)) |-> carry_out);
endmodule

bind cascade_counter cascade_counter_chk #(.W(W)) i_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .load_n    (load_n),
    .data_in   (data_in),
    .en_par    (en_par),
    .en_trk    (en_trk),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/test_cascade_counter.sv
module test_cascade_counter;
    localparam int  W       = 4;
    localparam time CLK_PER = 10;

    logic         clk = 1'b0;
    logic         clear_n, load_n, en_par, en_trk;
    logic [7:0]   din;
    logic [W-1:0] cnt_lo, cnt_hi;
    logic         carry_lo, carry_hi;

    int  checks = 0;
    int  fails  = 0;
    logic [7:0] model;
    bit  model_ok = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    cascade_counter #(.W(W)) i_cascade_counter (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .data_in(din[3:0]),
        .en_par(en_par), .en_trk(en_trk), .count(cnt_lo), .carry_out(carry_lo));

    cascade_counter #(.W(W)) i_cascade_counter_hi (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .data_in(din[7:4]),
        .en_par(en_par), .en_trk(carry_lo), .count(cnt_hi), .carry_out(carry_hi));

    function automatic logic [7:0] next_model(logic [7:0] cur, logic c_n, logic l_n,
                                              logic [7:0] d, logic ep, logic et);
        if (!c_n)           return 8'd0;
        else if (!l_n)      return d;
        else if (ep && et)  return cur + 8'd1;
        else                return cur;
    endfunction

    function automatic string tag_of(logic [7:0] cur, logic c_n, logic l_n, logic ep, logic et);
        if (!c_n)               return "R1";
        else if (!l_n)          return "R2";
        else if (!(ep && et))   return "R4";
        else if (cur[3:0] == 4'hF) return "R5/R7";
        else                    return "R3";
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Apply one cycle of controls at the falling edge, check the carry, then the count.
    task automatic step(logic c_n, logic l_n, logic [7:0] d, logic ep, logic et);
        string tag;
        @(negedge clk);
        clear_n = c_n; load_n = l_n; din = d; en_par = ep; en_trk = et;
        #1;
        if (model_ok) begin
            check("R6 carry lo", {7'd0, carry_lo}, {7'd0, et && (model[3:0] == 4'hF)});
            check("R6/R7 carry hi", {7'd0, carry_hi}, {7'd0, et && (model == 8'hFF)});
        end
        tag = tag_of(model, c_n, l_n, ep, et);
        model = next_model(model, c_n, l_n, d, ep, et);
        @(posedge clk);
        #1;
        if (!c_n) model_ok = 1'b1;
        if (model_ok) check(tag, {cnt_hi, cnt_lo}, model);
    endtask

    initial begin
        #(CLK_PER * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4650));
        clear_n = 1'b1; load_n = 1'b1; din = '0; en_par = 1'b0; en_trk = 1'b0;
        model = '0;

        // Reset state via clear, with load and enables also active (R1).
        step(1'b0, 1'b0, 8'hA5, 1'b1, 1'b1);
        // Load overrides enables (R2), then hold with each enable low (R4).
        step(1'b1, 1'b0, 8'h3C, 1'b1, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b0);
        // Carry with en_par low at all ones (R6), then counting across the stage boundary (R3, R5, R7).
        step(1'b1, 1'b0, 8'hFE, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
        // Load in the middle of a run, then clear together with a load (R2, R1).
        step(1'b1, 1'b0, 8'h0F, 1'b1, 1'b1);
        step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);
        step(1'b0, 1'b0, 8'h77, 1'b1, 1'b1);
        // Free run from zero through a full 8-bit wrap (R3, R5, R7).
        for (int i = 0; i < 260; i++) step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1);

        // Constrained random mix of all controls.
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 16) != 0, ($urandom % 12) != 0, 8'($urandom),
                 ($urandom % 4) != 0, ($urandom % 4) != 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule